// File: doc/BRIEF.md
# Attribute-Driven Data Cache Controller

This block is a small direct-mapped data cache that sits between a processor load/store port and a word-wide memory bus. Each request carries three attribute bits that select the cache policy for that access only. The write-through bit (W) chooses whether a store also goes to memory at once or waits until its line is evicted. The caching-inhibited bit (I) sends the access straight to memory without touching the cache. The coherency bit (M) marks the resulting bus traffic as global. A request can also be a barrier, which completes at once and has no other effect.

The cache holds 16 lines of four 32-bit words. Each line has a valid bit, a dirty bit and a tag. Byte address bits [3:2] select the word, bits [7:4] select the line, and bits [31:8] form the tag. Only one request is in flight at a time, so every access reaches the bus in program order. Each inhibited access is issued as exactly one bus beat of its own and is never merged with another. Line refills and copy-backs move the four words of a line in ascending word order.

Top module: `dc_attr_ctrl`

## Requirements
- R1: A load with I=0 that hits returns the cached word, makes no bus access, and raises `rsp_valid` two cycles after acceptance.
- R2: A store with W=0, I=0 that hits updates only the cached word and marks the line dirty. No bus access takes place, and memory keeps its old value until the line is copied back.
- R3: A store with W=1, I=0 issues exactly one bus write of its word and address. On a hit it also updates the cached word. On a miss no line is allocated, so a later load of that line misses.
- R4: A load with I=0, or a store with W=0, I=0, that misses fetches the whole line as four reads with byte addresses base, base+4, base+8 and base+12. The line is then installed as valid and the access completes from the cache.
- R5: When a miss replaces a valid dirty line, the four words of the old line are written to memory in ascending order before any read of the new line.
- R6: An access with I=1 makes exactly one bus beat at the request address. It returns the memory data for a load. It neither reads into, writes, allocates nor changes any cache line.
- R7: `rsp_err` is high together with `rsp_valid` for one cycle when an I=1 access finds its line resident. It is low for every other response.
- R8: While `mem_valid` is high, `mem_global` equals the M bit of the request being served, copy-back beats included.
- R9: A barrier request raises `rsp_valid` in the cycle after acceptance, with no bus access and no change to cache contents.
- R10: Once a request is accepted, `req_ready` stays low until its response has been given. No bus beat occurs while `req_ready` is high, so bus accesses follow request order.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R12: After reset `req_ready` is high, `rsp_valid` and `mem_valid` are low, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_barrier | input | 1 | Barrier request; other fields ignored |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| req_attr_w | input | 1 | Write-through attribute |
| req_attr_i | input | 1 | Caching-inhibited attribute |
| req_attr_m | input | 1 | Coherency-required attribute |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Load data, valid with rsp_valid |
| rsp_err | output | 1 | Inhibited access found its line resident |
| mem_valid | output | 1 | Bus beat requested |
| mem_ready | input | 1 | Bus accepts the beat (read data valid in the same cycle) |
| mem_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_global | output | 1 | Beat belongs to a coherent access |

## Verification
A sweep loads every one of the 16 lines twice. This separates a cold miss (four ascending reads) from a hit (no bus traffic, fixed latency) for every index and word offset. Stores are then tried under each W and I combination, on both resident and absent lines. The bus beat counts and the values left in the bench memory separate write-back, write-through, no-allocate and bypass behaviour. Conflicting tags on the same index force copy-back of a dirty line, and its write-before-read order is checked. Inhibited accesses to resident lines tell the error flag apart from the bypass. Loads that hit after those accesses show that the cache copy was left alone. A ready signal that stalls every third cycle exercises the bus hold rule.

// File: rtl/dc_pkg.sv
// Shared types for the attribute-driven data cache controller.
package dc_pkg;

    // Controller sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_WB,
        ST_FILL,
        ST_SINGLE,
        ST_RESP
    } dc_state_e;

    // Per-access policy bits carried with a request.
    typedef struct packed {
        logic wt;   // store goes to memory at once
        logic inh;  // bypass the cache entirely
        logic coh;  // bus traffic is global
    } dc_attr_t;

endpackage

// File: rtl/dc_tag_store.sv
// Tag, valid and dirty state for a direct-mapped cache.
// One combinational read port and one synchronous write port.
// Assumes LINES is a power of two. Only valid and dirty bits are reset.
module dc_tag_store #(
    parameter int LINES = 16,
    parameter int TAG_W = 24,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_dirty,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [LINES-1:0] vld_vec;
    logic [LINES-1:0] drt_vec;
    logic [TAG_W-1:0] tag_arr [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic             v_q;
        logic             d_q;
        logic [TAG_W-1:0] t_q;

        // Per-line state update; a write always leaves the line valid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                v_q <= 1'b1;
                d_q <= wr_dirty;
                t_q <= wr_tag;
            end
        end

        assign vld_vec[g] = v_q;
        assign drt_vec[g] = d_q;
        assign tag_arr[g] = t_q;
    end

    // Read port selects the addressed line.
    always_comb begin
        rd_valid = vld_vec[rd_idx];
        rd_dirty = drt_vec[rd_idx];
        rd_tag   = tag_arr[rd_idx];
    end

endmodule

// File: rtl/dc_data_store.sv
// Word storage for a direct-mapped cache: LINES lines of WORDS words.
// Combinational read, synchronous single-word write. No reset; contents
// are only meaningful for lines marked valid in the tag store.
module dc_data_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] mem_q [LINES*WORDS];

    // Single-word write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{wr_idx, wr_off}] <= wr_data;
        end
    end

    assign rd_data = mem_q[{rd_idx, rd_off}];

endmodule

// File: rtl/dc_attr_ctrl.sv
// Attribute-driven direct-mapped data cache controller.
// Each request picks its own policy from write-through, inhibited and
// coherent attribute bits. One request is in flight at a time. The memory
// bus moves one word per valid/ready beat, and read data is taken in the
// beat's handshake cycle. Assumes WORDS and LINES are powers of two.
module dc_attr_ctrl #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_barrier,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_attr_w,
    input  logic              req_attr_i,
    input  logic              req_attr_m,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_global
);
    import dc_pkg::*;

    localparam int IDX_W = $clog2(LINES);
    localparam int OFF_W = $clog2(WORDS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W - 2;
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

    dc_state_e         state_q, state_d;
    logic [OFF_W-1:0]  beat_q, beat_d;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic              err_q, err_d;

    logic              op_write_q;
    logic [ADDR_W-1:0] op_addr_q;
    logic [DATA_W-1:0] op_wdata_q;
    dc_attr_t          op_attr_q;

    logic [IDX_W-1:0]  op_idx;
    logic [OFF_W-1:0]  op_off;
    logic [TAG_W-1:0]  op_tag;

    logic              line_valid, line_dirty, hit;
    logic [TAG_W-1:0]  line_tag;
    logic [DATA_W-1:0] rd_word;
    logic [OFF_W-1:0]  rd_off;

    logic              td_we, td_dirty;
    logic              dd_we;
    logic [OFF_W-1:0]  dd_off;
    logic [DATA_W-1:0] dd_data;

    // Split the held request address into cache fields.
    assign op_off = op_addr_q[2 +: OFF_W];
    assign op_idx = op_addr_q[2 + OFF_W +: IDX_W];
    assign op_tag = op_addr_q[ADDR_W-1 -: TAG_W];

    assign rd_off = (state_q == ST_WB) ? beat_q : op_off;
    assign hit    = line_valid && (line_tag == op_tag);

    dc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (op_idx),
        .rd_valid (line_valid),
        .rd_dirty (line_dirty),
        .rd_tag   (line_tag),
        .wr_en    (td_we),
        .wr_idx   (op_idx),
        .wr_dirty (td_dirty),
        .wr_tag   (op_tag)
    );

    dc_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_idx  (op_idx),
        .rd_off  (rd_off),
        .rd_data (rd_word),
        .wr_en   (dd_we),
        .wr_idx  (op_idx),
        .wr_off  (dd_off),
        .wr_data (dd_data)
    );

    // Sequencing and cache update decisions.
    always_comb begin
        state_d  = state_q;
        beat_d   = beat_q;
        rdata_d  = rdata_q;
        err_d    = err_q;
        td_we    = 1'b0;
        td_dirty = 1'b0;
        dd_we    = 1'b0;
        dd_off   = op_off;
        dd_data  = op_wdata_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    err_d   = 1'b0;
                    state_d = req_barrier ? ST_RESP : ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                if (op_attr_q.inh) begin
                    err_d   = hit;
                    state_d = ST_SINGLE;
                end else if (hit) begin
                    if (!op_write_q) begin
                        rdata_d = rd_word;
                        state_d = ST_RESP;
                    end else begin
                        dd_we = 1'b1;
                        if (op_attr_q.wt) begin
                            state_d = ST_SINGLE;
                        end else begin
                            td_we    = 1'b1;
                            td_dirty = 1'b1;
                            state_d  = ST_RESP;
                        end
                    end
                end else if (op_write_q && op_attr_q.wt) begin
                    state_d = ST_SINGLE;
                end else begin
                    beat_d  = '0;
                    state_d = (line_valid && line_dirty) ? ST_WB : ST_FILL;
                end
            end
            ST_WB: begin
                if (mem_ready) begin
                    beat_d = beat_q + OFF_W'(1);
                    if (beat_q == LAST_BEAT) begin
                        state_d = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (mem_ready) begin
                    dd_we   = 1'b1;
                    dd_off  = beat_q;
                    dd_data = mem_rdata;
                    beat_d  = beat_q + OFF_W'(1);
                    if (beat_q == LAST_BEAT) begin
                        td_we   = 1'b1;
                        state_d = ST_DECIDE;
                    end
                end
            end
            ST_SINGLE: begin
                if (mem_ready) begin
                    if (!op_write_q) begin
                        rdata_d = mem_rdata;
                    end
                    state_d = ST_RESP;
                end
            end
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            rdata_q <= rdata_d;
            err_q   <= err_d;
        end
    end

    // Capture the request when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_write_q <= 1'b0;
            op_addr_q  <= '0;
            op_wdata_q <= '0;
            op_attr_q  <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            op_write_q <= req_write;
            op_addr_q  <= req_addr;
            op_wdata_q <= req_wdata;
            op_attr_q  <= '{wt: req_attr_w, inh: req_attr_i, coh: req_attr_m};
        end
    end

    // Bus beat contents follow from the registered state only.
    always_comb begin
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_WB: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {line_tag, op_idx, beat_q, 2'b00};
                mem_wdata = rd_word;
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = {op_tag, op_idx, beat_q, 2'b00};
            end
            ST_SINGLE: begin
                mem_valid = 1'b1;
                mem_write = op_write_q;
                mem_addr  = op_addr_q;
                mem_wdata = op_wdata_q;
            end
            default: ;
        endcase
        mem_global = mem_valid && op_attr_q.coh;
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_rdata = rdata_q;
    assign rsp_err   = rsp_valid && err_q;

endmodule

// File: rtl/dc_attr_ctrl_chk.sv
// Protocol checker for dc_attr_ctrl, attached by bind. It keeps its own
// copy of the accepted request's attributes and counts bus beats per
// request, so it does not depend on the controller's internal registers.
module dc_attr_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_barrier,
    input logic              req_attr_i,
    input logic              req_attr_m,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_global
);

    logic       coh_q, inh_q, bar_q;
    logic [3:0] beats_q;

    // Track the attributes and bus beat count of the current request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coh_q   <= 1'b0;
            inh_q   <= 1'b0;
            bar_q   <= 1'b0;
            beats_q <= '0;
        end else if (req_valid && req_ready) begin
            coh_q   <= req_attr_m;
            inh_q   <= req_attr_i;
            bar_q   <= req_barrier;
            beats_q <= '0;
        end else if (mem_valid && mem_ready && beats_q != 4'hF) begin
            beats_q <= beats_q + 4'd1;
        end
    end

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_no_bus_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_valid);

    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_write)
                                       && $stable(mem_addr) && $stable(mem_wdata)));

    assert_global_follows_m_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_global == coh_q));

    assert_barrier_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_barrier) |=> (rsp_valid && !mem_valid));

    assert_err_only_inhibited_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && inh_q && !bar_q));

    assert_inh_single_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && inh_q && !bar_q) |-> (beats_q == 4'd1));

endmodule

bind dc_attr_ctrl dc_attr_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_barrier (req_barrier),
    .req_attr_i  (req_attr_i),
    .req_attr_m  (req_attr_m),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_write   (mem_write),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_global  (mem_global)
);

// File: tb/dc_attr_ctrl_bench.sv
`timescale 1ns/1ps
// Self-checking bench: word memory model with a periodic stall on ready,
// a bus event log per request, and expected values worked out from the
// requirements.
module dc_attr_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_barrier = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_attr_w = 1'b0, req_attr_i = 1'b0, req_attr_m = 1'b0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        mem_valid, mem_write, mem_global;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #10 clk = ~clk;

    dc_attr_ctrl u_dc_attr_ctrl (.*);

    // Memory model and bus event log.
    logic [31:0] mem [256];
    logic [31:0] ev_addr [16];
    logic        ev_wr   [16];
    int          ev_n = 0, glob_hi = 0, glob_bad = 0, hold_bad = 0;
    int          cyc = 0, n_chk = 0, n_fail = 0;
    logic        cur_m = 1'b0;
    logic        stall_seen = 1'b0;
    logic [31:0] hold_addr, hold_wdata;
    logic        hold_wr;

    function automatic logic [31:0] initv(int k);
        return 32'hA500_0000 + 32'(k * 7);
    endfunction

    assign mem_rdata = mem[mem_addr[9:2]];

    always @(negedge clk) begin
        cyc <= cyc + 1;
        mem_ready <= ((cyc % 3) != 1);
    end

    always @(posedge clk) begin
        if (rst_n && mem_valid) begin
            if (mem_global !== cur_m) glob_bad++;
            if (stall_seen && (mem_addr !== hold_addr || mem_write !== hold_wr
                               || mem_wdata !== hold_wdata)) hold_bad++;
            stall_seen <= !mem_ready;
            hold_addr  <= mem_addr;
            hold_wr    <= mem_write;
            hold_wdata <= mem_wdata;
            if (mem_ready) begin
                if (ev_n < 16) begin
                    ev_addr[ev_n] = mem_addr;
                    ev_wr[ev_n]   = mem_write;
                end
                ev_n++;
                if (mem_global) glob_hi++;
                if (mem_write) mem[mem_addr[9:2]] = mem_wdata;
            end
        end else begin
            stall_seen <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [31:0] r_data;
    logic        r_err, r_busy;
    int          r_wr, r_rd, r_wait;

    task automatic do_req(input bit wr, input bit bar, input logic [31:0] a,
                          input logic [31:0] d, input bit w, input bit i, input bit m);
        @(negedge clk);
        ev_n = 0; glob_hi = 0; cur_m = m;
        req_valid = 1'b1; req_write = wr; req_barrier = bar; req_addr = a;
        req_wdata = d; req_attr_w = w; req_attr_i = i; req_attr_m = m;
        @(negedge clk);
        req_valid = 1'b0;
        r_busy = !req_ready;
        r_wait = 0;
        while (!rsp_valid && r_wait < 200) begin
            @(negedge clk);
            r_wait++;
        end
        r_data = rsp_rdata; r_err = rsp_err;
        r_wr = 0; r_rd = 0;
        for (int k = 0; k < ev_n && k < 16; k++) begin
            if (ev_wr[k]) r_wr++; else r_rd++;
        end
        if (r_wait >= 200) chk(0, "no response", 32'(r_wait), 0);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = initv(k);
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_valid === 1'b0,
            "R12 reset outputs", {29'b0, req_ready, rsp_valid, mem_valid}, 32'h4);
        rst_n = 1'b1;

        // R4 / R1: sweep every line, cold miss then hit
        for (int x = 0; x < 16; x++) begin
            logic [31:0] a, base;
            a = 32'(x * 16 + 4 * (x % 4));
            base = 32'(x * 16);
            do_req(0, 0, a, 0, 0, 0, 0);
            chk(r_rd == 4 && r_wr == 0, "R4 miss beat count", 32'(r_rd), 4);
            chk(r_data === initv(a >> 2), "R4 miss data", r_data, initv(a >> 2));
            for (int k = 0; k < 4; k++)
                chk(ev_addr[k] === base + 32'(4 * k), "R4 fill order", ev_addr[k],
                    base + 32'(4 * k));
            do_req(0, 0, a, 0, 0, 0, 0);
            chk(r_rd == 0 && r_wr == 0, "R1 hit no bus", 32'(r_rd + r_wr), 0);
            chk(r_data === initv(a >> 2), "R1 hit data", r_data, initv(a >> 2));
            chk(r_wait == 1, "R1 hit latency", 32'(r_wait), 1);
        end

        // R2: write-back store hit stays in the cache
        do_req(1, 0, 32'h24, 32'hDEAD_0001, 0, 0, 0);
        chk(r_wr == 0 && r_rd == 0, "R2 no bus", 32'(r_wr + r_rd), 0);
        chk(mem[9] === initv(9), "R2 memory untouched", mem[9], initv(9));
        do_req(0, 0, 32'h24, 0, 0, 0, 0);
        chk(r_data === 32'hDEAD_0001, "R2 reads new value", r_data, 32'hDEAD_0001);

        // R5: conflicting tag evicts the dirty line first
        do_req(0, 0, 32'h124, 0, 0, 0, 0);
        chk(r_wr == 4 && r_rd == 4, "R5 beat counts", 32'(r_wr * 16 + r_rd), 32'h44);
        for (int k = 0; k < 4; k++) begin
            chk(ev_wr[k] === 1'b1 && ev_addr[k] === 32'h20 + 32'(4 * k),
                "R5 copy-back first", ev_addr[k], 32'h20 + 32'(4 * k));
            chk(ev_wr[k+4] === 1'b0 && ev_addr[k+4] === 32'h120 + 32'(4 * k),
                "R5 fill after", ev_addr[k+4], 32'h120 + 32'(4 * k));
        end
        chk(mem[9] === 32'hDEAD_0001, "R5 dirty word reached memory", mem[9], 32'hDEAD_0001);
        chk(r_data === initv(73), "R5 new line data", r_data, initv(73));

        // R3: write-through hit and miss
        do_req(1, 0, 32'h124, 32'h1111_2222, 1, 0, 0);
        chk(r_wr == 1 && r_rd == 0 && ev_addr[0] === 32'h124, "R3 hit one write",
            ev_addr[0], 32'h124);
        chk(mem[73] === 32'h1111_2222, "R3 memory updated", mem[73], 32'h1111_2222);
        do_req(0, 0, 32'h124, 0, 0, 0, 0);
        chk(r_rd == 0 && r_data === 32'h1111_2222, "R3 cache updated", r_data, 32'h1111_2222);
        do_req(1, 0, 32'h300, 32'h3333_4444, 1, 0, 0);
        chk(r_wr == 1 && r_rd == 0, "R3 miss one write", 32'(r_wr * 16 + r_rd), 32'h10);
        do_req(0, 0, 32'h300, 0, 0, 0, 0);
        chk(r_rd == 4 && r_wr == 0, "R3 miss did not allocate", 32'(r_rd), 4);
        chk(r_data === 32'h3333_4444, "R3 miss data", r_data, 32'h3333_4444);

        // R6 / R7: inhibited accesses
        do_req(0, 0, 32'h300, 0, 0, 1, 0);
        chk(r_err === 1'b1, "R7 resident inhibited load flags", {31'b0, r_err}, 1);
        chk(r_rd == 1 && r_wr == 0 && ev_addr[0] === 32'h300, "R6 single read",
            32'(r_rd), 1);
        do_req(1, 0, 32'h300, 32'h5555_6666, 0, 1, 0);
        chk(r_err === 1'b1 && r_wr == 1 && r_rd == 0, "R7 resident inhibited store",
            32'(r_wr), 1);
        chk(mem[8'hC0] === 32'h5555_6666, "R6 store bypassed to memory", mem[8'hC0],
            32'h5555_6666);
        do_req(0, 0, 32'h300, 0, 0, 0, 0);
        chk(r_rd == 0 && r_data === 32'h3333_4444 && r_err === 1'b0,
            "R6 cache line unchanged", r_data, 32'h3333_4444);
        do_req(1, 0, 32'h3F0, 32'h7777_8888, 0, 1, 0);
        chk(r_err === 1'b0 && r_wr == 1, "R7 absent inhibited no flag", {31'b0, r_err}, 0);
        do_req(0, 0, 32'h3F0, 0, 0, 1, 0);
        chk(r_rd == 1 && r_data === 32'h7777_8888 && r_err === 1'b0,
            "R6 inhibited load not allocated", r_data, 32'h7777_8888);
        do_req(0, 0, 32'h3F0, 0, 0, 0, 0);
        chk(r_rd == 4 && r_data === 32'h7777_8888, "R6 later cached load misses",
            32'(r_rd), 4);

        // R10: strict order and single outstanding request
        for (int k = 0; k < 4; k++) begin
            logic [31:0] a;
            a = 32'h10 + 32'(k * 68);
            do_req(1, 0, a, 32'hC0DE_0000 + 32'(k), 0, 1, 0);
            chk(r_busy && r_wr == 1 && ev_addr[0] === a, "R10 in-order single beat",
                ev_addr[0], a);
        end

        // R8: global flag on every beat of a coherent access
        do_req(0, 0, 32'h2A8, 0, 0, 0, 1);
        chk(glob_hi == 4 && r_rd == 4, "R8 fill beats global", 32'(glob_hi), 4);
        do_req(1, 0, 32'h2A8, 32'hFACE_0001, 0, 0, 1);
        do_req(0, 0, 32'h0A0, 0, 0, 0, 1);
        chk(glob_hi == 8 && r_wr == 4, "R8 copy-back beats global", 32'(glob_hi), 8);
        do_req(0, 0, 32'h0A0, 0, 0, 1, 0);
        chk(glob_hi == 0 && r_rd == 1, "R8 non-coherent beat low", 32'(glob_hi), 0);

        // R9: barrier
        do_req(0, 1, 32'h124, 0, 0, 0, 0);
        chk(r_wait == 0 && r_rd == 0 && r_wr == 0, "R9 barrier immediate", 32'(r_wait), 0);
        do_req(0, 0, 32'h124, 0, 0, 0, 0);
        chk(r_rd == 0 && r_data === 32'h1111_2222, "R9 cache unchanged", r_data,
            32'h1111_2222);

        chk(glob_bad == 0, "R8 global mismatches", 32'(glob_bad), 0);
        chk(hold_bad == 0, "R11 beat held while stalled", 32'(hold_bad), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule